// File: doc/BRIEF.md
# Preemption-aware scratchpad transfer engine

This engine moves data between a word-wide external memory and a scratchpad that several preemptible tasks share. The scratchpad has two spaces, each built from equal blocks of `BLOCK_WORDS` words. Tasks may only read the read-only space, and only the engine writes it. Tasks may write the read-write space. The engine keeps one tag for every block. A tag holds a valid bit and the external base address that the block's contents belong to.

An operating system issues one command at a time. Each command carries an opcode, an external address, a first block index and a block count. Load commands fill blocks and set their tags. Writeback copies read-write blocks out to their tagged addresses. Take-ownership sets read-write tags without moving any data. Save and Restore handle a context switch over blocks `0..count-1` of one space. Save writes one tag record per block into a context area in external memory. For read-write blocks it also writes the contents back. Restore reads those records and refills each block whose record is valid. In this way a switch costs only the blocks the task actually uses.

Top module: `spm_xfer_engine`

## Requirements
- R1: A command is taken on a clock edge where `cmd_valid` is high and `busy` is low, and `busy` is high in the next cycle. While `busy` is high, `cmd_valid` has no effect. `done` is high for exactly one cycle at the end of a command, and `busy` is low in the cycle after `done`.
- R2: A command is rejected if first block plus count is greater than the number of blocks in its space. For Save and Restore the first block is always 0. A rejected command finishes with `err` high together with `done`. It makes no memory request, does not use the scratchpad and leaves every tag unchanged.
- R3: The opcodes are: 0 load read-only, 1 load read-write, 2 writeback, 3 take-ownership, 4 save read-only, 5 save read-write, 6 restore read-only, 7 restore read-write. A load fills block `blk+i` for i from 0 to cnt-1. Word w of that block comes from external address `addr + i*BLOCK_WORDS + w`. The block's tag is set to that base address with the valid bit set. Scratchpad word address = block*BLOCK_WORDS + w, and `spm_rw` selects the space (1 = read-write).
- R4: Writeback copies each read-write block in the range to its tagged address, word by word. Blocks whose tag is not valid are skipped and cause no request.
- R5: Take-ownership sets read-write tag `blk+i` to `addr + i*BLOCK_WORDS` with the valid bit set. It makes no memory request and no scratchpad write.
- R6: Save writes one record per block to address `addr + b` for b from 0 to cnt-1, in ascending order. Record bit `DATA_W-1` is the valid bit, bits `ADDR_W-1:0` are the tag address, and all other bits are 0. For a valid read-write block, the block contents then go to the tagged address. Invalid blocks write only their record.
- R7: Restore reads the records at `addr + b`, loads each one into tag b, and refills block b from the record's address only when the record is valid.
- R8: After reset `busy`, `done`, `mem_req` and `spm_en` are low and every tag is invalid.
- R9: A memory request holds its address, direction and write data until `mem_ack`. Each acknowledge moves exactly one word.
- R10: A count of zero finishes with `done`, with `err` low and with no transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_op | input | 3 | Opcode (see R3) |
| cmd_ext_addr | input | ADDR_W | External base address or context area address |
| cmd_blk | input | BLK_W | First block index |
| cmd_cnt | input | CNT_W | Number of blocks |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Range error, valid with done |
| mem_req | output | 1 | External word request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | External word address |
| mem_wdata | output | DATA_W | External write data |
| mem_ack | input | 1 | Request completed |
| mem_rdata | input | DATA_W | Read data, valid with mem_ack |
| spm_en | output | 1 | Scratchpad access |
| spm_we | output | 1 | Scratchpad write |
| spm_rw | output | 1 | Space select, 1 = read-write |
| spm_addr | output | SPM_AW | Scratchpad word address within the space |
| spm_wdata | output | DATA_W | Scratchpad write data |
| spm_rdata | input | DATA_W | Scratchpad read data, one cycle after a read |

## Verification
Two events can land in the same cycle: the end of one command (`done` high) and a new command that is still being offered. The bench provokes this by holding a take-ownership command on the port for every cycle in which `busy` is high, done cycle included, and dropping it once `busy` is seen low. It then judges the outcome with a later Save of the read-write tags, whose records must show that ownership was never applied. The memory acknowledge latency is swept from zero to two cycles, so a request and its acknowledge can also fall on adjacent edges.

// File: rtl/spm_xfer_pkg.sv
package spm_xfer_pkg;

  typedef enum logic [2:0] {
    OP_LOAD_RO = 3'd0,
    OP_LOAD_RW = 3'd1,
    OP_WBACK   = 3'd2,
    OP_OWN     = 3'd3,
    OP_SAVE_RO = 3'd4,
    OP_SAVE_RW = 3'd5,
    OP_REST_RO = 3'd6,
    OP_REST_RW = 3'd7
  } xfer_op_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_BLK, ST_TAGW, ST_TAGR, ST_IN_REQ, ST_IN_WR,
    ST_OUT_RD, ST_OUT_CAP, ST_OUT_REQ, ST_NEXT, ST_DONE
  } xfer_st_e;

  // 1 selects the read-write space
  function automatic logic op_space(xfer_op_e op);
    return (op == OP_LOAD_RW) || (op == OP_WBACK) || (op == OP_OWN) ||
           (op == OP_SAVE_RW) || (op == OP_REST_RW);
  endfunction

  function automatic logic op_ctx(xfer_op_e op);
    return op[2];
  endfunction

  function automatic int unsigned blk_base(int unsigned ext, int unsigned idx,
                                           int unsigned words);
    return ext + idx * words;
  endfunction

  function automatic logic range_fits(int unsigned first, int unsigned cnt,
                                      int unsigned nblk);
    return (first + cnt) <= nblk;
  endfunction

endpackage

// File: rtl/spm_tag_file.sv
module spm_tag_file #(
  parameter int IW = 2,
  parameter int AW = 10,
  localparam int NIDX = 1 << IW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_sp,
  input  logic [IW-1:0] wr_idx,
  input  logic          wr_valid,
  input  logic [AW-1:0] wr_addr,
  input  logic          rd_sp,
  input  logic [IW-1:0] rd_idx,
  output logic          rd_valid,
  output logic [AW-1:0] rd_addr
);
  logic [1:0]    sp_valid;
  logic [AW-1:0] sp_addr [2];

  for (genvar s = 0; s < 2; s++) begin : g_space
    logic [NIDX-1:0] v_q;
    logic [AW-1:0]   a_q [NIDX];
    logic            hit;

    assign hit = wr_en && (wr_sp == 1'(s));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   v_q <= '0;
      else if (hit) v_q[wr_idx] <= wr_valid;
    end

    always_ff @(posedge clk) begin
      if (hit) a_q[wr_idx] <= wr_addr;
    end

    assign sp_valid[s] = v_q[rd_idx];
    assign sp_addr[s]  = a_q[rd_idx];
  end

  assign rd_valid = sp_valid[rd_sp];
  assign rd_addr  = sp_addr[rd_sp];
endmodule

// File: rtl/spm_word_ctr.sv
module spm_word_ctr #(
  parameter int WORDS = 4,
  localparam int WW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [WW-1:0] idx,
  output logic          last
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   idx <= '0;
    else if (clr) idx <= '0;
    else if (inc) idx <= idx + 1'b1;
  end

  assign last = (idx == WW'(WORDS - 1));
endmodule

// File: rtl/spm_xfer_engine.sv
module spm_xfer_engine
  import spm_xfer_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 16,
  parameter int BLOCK_WORDS = 4,
  parameter int RO_BLKS     = 4,
  parameter int RW_BLKS     = 4,
  localparam int NB_MAX = (RO_BLKS > RW_BLKS) ? RO_BLKS : RW_BLKS,
  localparam int BLK_W  = $clog2(NB_MAX),
  localparam int CNT_W  = $clog2(NB_MAX + 1),
  localparam int WRD_W  = $clog2(BLOCK_WORDS),
  localparam int SPM_AW = BLK_W + WRD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_ext_addr,
  input  logic [BLK_W-1:0]  cmd_blk,
  input  logic [CNT_W-1:0]  cmd_cnt,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              spm_en,
  output logic              spm_we,
  output logic              spm_rw,
  output logic [SPM_AW-1:0] spm_addr,
  output logic [DATA_W-1:0] spm_wdata,
  input  logic [DATA_W-1:0] spm_rdata
);
  xfer_st_e          state;
  xfer_op_e          op_q, op_d;
  logic              sp_q, range_bad_q;
  logic [BLK_W-1:0]  blk0_q, blk_d, cur_blk;
  logic [CNT_W-1:0]  cnt_q, bi_q;
  logic [ADDR_W-1:0] ext_q, cur_q, blk_addr, tag_raddr, tag_waddr;
  logic [DATA_W-1:0] buf_q, tag_rec;
  logic              tag_rvalid, tag_we, tag_wvalid;
  logic [WRD_W-1:0]  word_idx;
  logic              word_last, word_clr, word_inc;
  logic              accept, fits, blk_start, own_active, last_blk;
  int unsigned       space_blks;

  // decode of the offered command
  assign accept     = cmd_valid && (state == ST_IDLE);
  assign op_d       = xfer_op_e'(cmd_op);
  assign blk_d      = op_ctx(op_d) ? '0 : cmd_blk;
  assign space_blks = op_space(op_d) ? RW_BLKS : RO_BLKS;
  assign fits       = range_fits(32'(blk_d), 32'(cmd_cnt), space_blks);

  assign cur_blk    = blk0_q + BLK_W'(bi_q);
  assign blk_addr   = ADDR_W'(blk_base(32'(ext_q), 32'(bi_q), BLOCK_WORDS));
  assign last_blk   = (CNT_W'(bi_q + 1'b1) == cnt_q);
  assign blk_start  = (state == ST_BLK);
  assign own_active = busy && (op_q == OP_OWN);

  always_comb begin
    tag_rec                = '0;
    tag_rec[DATA_W-1]      = tag_rvalid;
    tag_rec[ADDR_W-1:0]    = tag_raddr;
  end

  // tag updates: load and ownership at block start, restore on record arrival
  always_comb begin
    tag_we     = 1'b0;
    tag_wvalid = 1'b1;
    tag_waddr  = blk_addr;
    if (blk_start && (op_q == OP_LOAD_RO || op_q == OP_LOAD_RW || op_q == OP_OWN))
      tag_we = 1'b1;
    if (state == ST_TAGR && mem_ack) begin
      tag_we     = 1'b1;
      tag_wvalid = mem_rdata[DATA_W-1];
      tag_waddr  = mem_rdata[ADDR_W-1:0];
    end
  end

  spm_tag_file #(.IW(BLK_W), .AW(ADDR_W)) u_tags (
    .clk, .rst_n,
    .wr_en(tag_we), .wr_sp(sp_q), .wr_idx(cur_blk),
    .wr_valid(tag_wvalid), .wr_addr(tag_waddr),
    .rd_sp(sp_q), .rd_idx(cur_blk),
    .rd_valid(tag_rvalid), .rd_addr(tag_raddr)
  );

  assign word_clr = blk_start;
  assign word_inc = ((state == ST_IN_WR) && !word_last) ||
                    ((state == ST_OUT_REQ) && mem_ack && !word_last);

  spm_word_ctr #(.WORDS(BLOCK_WORDS)) u_words (
    .clk, .rst_n, .clr(word_clr), .inc(word_inc),
    .idx(word_idx), .last(word_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      op_q        <= OP_LOAD_RO;
      sp_q        <= 1'b0;
      range_bad_q <= 1'b0;
      blk0_q      <= '0;
      cnt_q       <= '0;
      bi_q        <= '0;
      ext_q       <= '0;
      cur_q       <= '0;
      buf_q       <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          op_q        <= op_d;
          sp_q        <= op_space(op_d);
          blk0_q      <= blk_d;
          cnt_q       <= cmd_cnt;
          ext_q       <= cmd_ext_addr;
          bi_q        <= '0;
          range_bad_q <= !fits;
          state       <= (!fits || cmd_cnt == '0) ? ST_DONE : ST_BLK;
        end
        ST_BLK: begin
          unique case (op_q)
            OP_LOAD_RO, OP_LOAD_RW: begin
              cur_q <= blk_addr;
              state <= ST_IN_REQ;
            end
            OP_OWN: state <= ST_NEXT;
            OP_WBACK: begin
              cur_q <= tag_raddr;
              state <= tag_rvalid ? ST_OUT_RD : ST_NEXT;
            end
            OP_SAVE_RO, OP_SAVE_RW: state <= ST_TAGW;
            default:                state <= ST_TAGR;
          endcase
        end
        ST_TAGW: if (mem_ack) begin
          cur_q <= tag_raddr;
          state <= (sp_q && tag_rvalid) ? ST_OUT_RD : ST_NEXT;
        end
        ST_TAGR: if (mem_ack) begin
          cur_q <= mem_rdata[ADDR_W-1:0];
          state <= mem_rdata[DATA_W-1] ? ST_IN_REQ : ST_NEXT;
        end
        ST_IN_REQ: if (mem_ack) begin
          buf_q <= mem_rdata;
          state <= ST_IN_WR;
        end
        ST_IN_WR:   state <= word_last ? ST_NEXT : ST_IN_REQ;
        ST_OUT_RD:  state <= ST_OUT_CAP;
        ST_OUT_CAP: begin
          buf_q <= spm_rdata;
          state <= ST_OUT_REQ;
        end
        ST_OUT_REQ: if (mem_ack) state <= word_last ? ST_NEXT : ST_OUT_RD;
        ST_NEXT: begin
          if (last_blk) state <= ST_DONE;
          else begin
            bi_q  <= bi_q + 1'b1;
            state <= ST_BLK;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_DONE);
  assign err  = done && range_bad_q;

  assign mem_req   = (state == ST_TAGW) || (state == ST_TAGR) ||
                     (state == ST_IN_REQ) || (state == ST_OUT_REQ);
  assign mem_we    = (state == ST_TAGW) || (state == ST_OUT_REQ);
  assign mem_addr  = (state == ST_TAGW || state == ST_TAGR) ?
                     ext_q + ADDR_W'(bi_q) : cur_q + ADDR_W'(word_idx);
  assign mem_wdata = (state == ST_TAGW) ? tag_rec : buf_q;

  assign spm_en    = (state == ST_IN_WR) || (state == ST_OUT_RD);
  assign spm_we    = (state == ST_IN_WR);
  assign spm_rw    = sp_q;
  assign spm_addr  = {cur_blk, word_idx};
  assign spm_wdata = buf_q;
endmodule

// File: rtl/spm_xfer_engine_chk.sv
module spm_xfer_engine_chk #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic              mem_req,
  input logic              mem_ack,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              spm_en,
  input logic              spm_we,
  input logic              own_active,
  input logic              range_bad_q
);
  // R1
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy) |=> busy);

  // R1
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  // R2
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  // R2
  reject_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && range_bad_q) |-> (!mem_req && !spm_en));

  // R5
  own_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    own_active |-> (!mem_req && !spm_we));

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) &&
                               $stable(mem_we) && $stable(mem_wdata)));

  // R3
  port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spm_we |-> !mem_req);
endmodule

bind spm_xfer_engine spm_xfer_engine_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .busy(busy), .done(done),
  .err(err), .mem_req(mem_req), .mem_ack(mem_ack), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .spm_en(spm_en), .spm_we(spm_we),
  .own_active(own_active), .range_bad_q(range_bad_q)
);

// File: tb/spm_xfer_engine_bench.sv
module spm_xfer_engine_bench;
  localparam int AW = 10, DW = 16, BW = 4, NB = 4;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0;
  logic [2:0] cmd_op = 0;
  logic [AW-1:0] cmd_ext_addr = 0;
  logic [1:0] cmd_blk = 0;
  logic [2:0] cmd_cnt = 0;
  logic busy, done, err, mem_req, mem_we, spm_en, spm_we, spm_rw;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, spm_wdata;
  logic mem_ack = 0;
  logic [DW-1:0] mem_rdata = 0, spm_rdata = 0;
  logic [3:0] spm_addr;

  always #5 clk = ~clk;

  spm_xfer_engine u_spm_xfer_engine (
    .clk, .rst_n, .cmd_valid, .cmd_op, .cmd_ext_addr, .cmd_blk, .cmd_cnt,
    .busy, .done, .err, .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_ack,
    .mem_rdata, .spm_en, .spm_we, .spm_rw, .spm_addr, .spm_wdata, .spm_rdata
  );

  // external memory and scratchpad models
  logic [DW-1:0] ext_mem [1024];
  logic [DW-1:0] spm_mem [2][16];
  int mem_lat = 0, wcnt = 0;
  int nacc = 0, nspw = 0;

  always @(posedge clk) begin
    if (mem_ack) begin
      mem_ack <= 0;
      wcnt    <= 0;
    end else if (mem_req) begin
      if (wcnt >= mem_lat) begin
        mem_ack <= 1;
        if (mem_we) ext_mem[mem_addr] <= mem_wdata;
        else        mem_rdata <= ext_mem[mem_addr];
      end else wcnt <= wcnt + 1;
    end
    if (spm_en) begin
      if (spm_we) spm_mem[spm_rw][spm_addr] <= spm_wdata;
      else        spm_rdata <= spm_mem[spm_rw][spm_addr];
    end
    if (mem_req && mem_ack) nacc <= nacc + 1;
    if (spm_en && spm_we)   nspw <= nspw + 1;
  end

  // expected model, written from the requirements
  logic [DW-1:0] m_ext [1024];
  logic [DW-1:0] m_spm [2][16];
  logic          m_tv  [2][4];
  logic [AW-1:0] m_ta  [2][4];

  int errors = 0, checks = 0;
  logic last_err;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cmp_all(input string req);
    int bad = -1, a = 0, e = 0;
    for (int i = 0; i < 1024; i++)
      if (bad < 0 && ext_mem[i] !== m_ext[i]) begin bad = i; a = ext_mem[i]; e = m_ext[i]; end
    for (int s = 0; s < 2; s++)
      for (int i = 0; i < 16; i++)
        if (bad < 0 && spm_mem[s][i] !== m_spm[s][i]) begin
          bad = 2000 + s * 16 + i; a = spm_mem[s][i]; e = m_spm[s][i];
        end
    if (bad >= 0) $display("FAIL %s mismatch at location %0d", req, bad);
    chk(bad < 0, req, a, e);
  endtask

  task automatic m_load(input int sp, input int blk, input int cnt, input int a);
    for (int i = 0; i < cnt; i++) begin
      int b = blk + i;
      m_tv[sp][b] = 1;
      m_ta[sp][b] = AW'(a + i * BW);
      for (int w = 0; w < BW; w++) m_spm[sp][b * BW + w] = m_ext[(m_ta[sp][b] + w) % 1024];
    end
  endtask

  task automatic m_own(input int blk, input int cnt, input int a);
    for (int i = 0; i < cnt; i++) begin
      m_tv[1][blk + i] = 1;
      m_ta[1][blk + i] = AW'(a + i * BW);
    end
  endtask

  task automatic m_wb(input int blk, input int cnt);
    for (int b = blk; b < blk + cnt; b++)
      if (m_tv[1][b])
        for (int w = 0; w < BW; w++) m_ext[(m_ta[1][b] + w) % 1024] = m_spm[1][b * BW + w];
  endtask

  task automatic m_save(input int sp, input int cnt, input int ctx);
    for (int b = 0; b < cnt; b++) begin
      m_ext[ctx + b] = {m_tv[sp][b], 5'b0, m_ta[sp][b]};
      if (sp == 1 && m_tv[1][b])
        for (int w = 0; w < BW; w++) m_ext[(m_ta[1][b] + w) % 1024] = m_spm[1][b * BW + w];
    end
  endtask

  task automatic m_restore(input int sp, input int cnt, input int ctx);
    for (int b = 0; b < cnt; b++) begin
      logic [DW-1:0] r = m_ext[ctx + b];
      m_tv[sp][b] = r[DW-1];
      m_ta[sp][b] = r[AW-1:0];
      if (r[DW-1])
        for (int w = 0; w < BW; w++) m_spm[sp][b * BW + w] = m_ext[(r[AW-1:0] + w) % 1024];
    end
  endtask

  task automatic issue(input int op, input int blk, input int cnt, input int a);
    @(negedge clk);
    nacc = 0; nspw = 0;
    cmd_valid = 1; cmd_op = 3'(op); cmd_blk = 2'(blk); cmd_cnt = 3'(cnt);
    cmd_ext_addr = AW'(a);
    @(negedge clk);
    cmd_valid = 0;
    chk(busy === 1'b1, "R1 busy after accept", int'(busy), 1);
    while (done !== 1'b1) @(negedge clk);
    last_err = err;
    @(negedge clk);
    chk(busy === 1'b0, "R1 busy low after done", int'(busy), 0);
  endtask

  task automatic run_ok(input int op, input int blk, input int cnt, input int a,
                        input string req);
    issue(op, blk, cnt, a);
    chk(last_err === 1'b0, req, int'(last_err), 0);
  endtask

  always @(posedge clk) begin
    if ($time > 64'd1_500_000) begin
      errors++; checks++;
      $display("FAIL R1 watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 1024; i++) begin
      ext_mem[i] = DW'(i * 37 + 5); m_ext[i] = ext_mem[i];
    end
    for (int s = 0; s < 2; s++) begin
      for (int i = 0; i < 16; i++) begin spm_mem[s][i] = 0; m_spm[s][i] = 0; end
      for (int b = 0; b < 4; b++) begin m_tv[s][b] = 0; m_ta[s][b] = 0; end
    end
    repeat (3) @(negedge clk);
    // R8: idle outputs during reset
    chk(busy === 0 && done === 0 && mem_req === 0 && spm_en === 0, "R8 reset outputs",
        {busy, done, mem_req, spm_en}, 0);
    rst_n = 1;
    @(negedge clk);

    // R8: records after reset all invalid; R6 read-only save writes records only
    run_ok(4, 0, 4, 'h300, "R8 save after reset");
    m_save(0, 4, 'h300);
    cmp_all("R8 records invalid after reset");
    chk(nacc == 4 && nspw == 0, "R6 read-only save moves records only", nacc, 4);

    // R4: invalid blocks skipped
    run_ok(2, 0, 4, 0, "R4 writeback");
    chk(nacc == 0, "R4 invalid blocks skipped", nacc, 0);

    // R3 / R9: load sweep over spaces, first blocks, counts and latencies
    for (int sp = 0; sp < 2; sp++)
      for (int blk = 0; blk < NB; blk++)
        for (int cnt = 1; cnt <= NB - blk; cnt++) begin
          int a = sp * 128 + blk * 32 + cnt * 4;
          mem_lat = (blk + cnt) % 3;
          run_ok(sp, blk, cnt, a, "R3 load no error");
          m_load(sp, blk, cnt, a);
          cmp_all("R3 load contents");
          chk(nacc == cnt * BW, "R9 one word per acknowledge", nacc, cnt * BW);
        end

    // R2: range errors
    mem_lat = 1;
    for (int blk = 0; blk < NB; blk++)
      for (int cnt = NB - blk + 1; cnt <= 7; cnt++) begin
        issue(1, blk, cnt, 'h40);
        chk(last_err === 1'b1, "R2 range error flagged", int'(last_err), 1);
        chk(nacc == 0 && nspw == 0, "R2 no transfers on error", nacc + nspw, 0);
      end
    issue(7, 3, 5, 'h300);
    chk(last_err === 1'b1, "R2 restore count too large", int'(last_err), 1);
    cmp_all("R2 state unchanged");

    // R10: zero count
    run_ok(0, 1, 0, 'h10, "R10 zero count no error");
    chk(nacc == 0 && nspw == 0, "R10 zero count no transfers", nacc + nspw, 0);

    // R5: ownership without data movement
    run_ok(3, 1, 2, 'h200, "R5 own");
    m_own(1, 2, 'h200);
    chk(nacc == 0 && nspw == 0, "R5 own makes no transfers", nacc + nspw, 0);
    cmp_all("R5 contents untouched");

    // R4: writeback uses tags
    mem_lat = 0;
    run_ok(2, 0, 4, 0, "R4 writeback");
    m_wb(0, 4);
    cmp_all("R4 writeback to tagged addresses");
    chk(nacc == 16, "R4 writeback word count", nacc, 16);

    // R6: saves
    mem_lat = 2;
    run_ok(5, 0, 3, 'h380, "R6 save rw");
    m_save(1, 3, 'h380);
    chk(nacc == 15, "R6 rw save records plus contents", nacc, 15);
    run_ok(4, 0, 4, 'h300, "R6 save ro");
    m_save(0, 4, 'h300);
    cmp_all("R6 context records and contents");

    // clobber, then R7 restore
    mem_lat = 1;
    run_ok(0, 0, 4, 'h100, "R3 clobber ro"); m_load(0, 0, 4, 'h100);
    run_ok(1, 0, 4, 'h180, "R3 clobber rw"); m_load(1, 0, 4, 'h180);
    run_ok(6, 0, 4, 'h300, "R7 restore ro"); m_restore(0, 4, 'h300);
    run_ok(7, 0, 3, 'h380, "R7 restore rw"); m_restore(1, 3, 'h380);
    cmp_all("R7 contents back as before preemption");

    // R7 / R6: invalid record
    @(negedge clk); ext_mem['h3A0] = 0; m_ext['h3A0] = 0;
    run_ok(7, 0, 1, 'h3A0, "R7 restore invalid");
    m_restore(1, 1, 'h3A0);
    chk(nacc == 1 && nspw == 0, "R7 invalid record not refilled", nacc + nspw, 1);
    run_ok(5, 0, 1, 'h3B0, "R6 save invalid");
    m_save(1, 1, 'h3B0);
    chk(nacc == 1, "R6 invalid block record only", nacc, 1);
    cmp_all("R6 invalid record written");

    // R1: command held during busy, including the done cycle, is ignored
    mem_lat = 0;
    @(negedge clk);
    cmd_valid = 1; cmd_op = 0; cmd_blk = 2; cmd_cnt = 1; cmd_ext_addr = 'h20;
    @(negedge clk);
    cmd_op = 3; cmd_blk = 0; cmd_cnt = 4; cmd_ext_addr = 'h3C0;
    while (busy === 1'b1) @(negedge clk);
    cmd_valid = 0;
    m_load(0, 2, 1, 'h20);
    repeat (2) @(negedge clk);
    chk(busy === 1'b0, "R1 held command not taken", int'(busy), 0);
    run_ok(5, 0, 4, 'h3E0, "R1 probe save");
    m_save(1, 4, 'h3E0);
    cmp_all("R1 ownership during busy had no effect");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule